// File: doc/BRIEF.md
# Multi-Mode Serial Baud Tick Generator

This block times the bit clock of a serial transceiver. A divisor held in two byte registers sets how many groups of clocks make up one sub-interval. The selected mode sets how many sub-intervals make up one bit: 4, 16 or 64. Three mode bits choose that multiplier: synchronous operation, a wide (16-bit) divisor, and a high-speed select. The high-speed select counts only in asynchronous operation. When a bit period ends, `baud_tick` pulses for one clock. Three `sample_tick` pulses fall around the middle of every bit, so a receiver can take three samples of its input line and vote on them.

Each divisor byte has its own write strobe. A third strobe loads the three mode bits together. Any of these writes clears both internal counters in the same cycle, so the new rate starts at once. Nothing has to wait for the old period to run out. After reset the divisor is zero and the mode bits are clear, which gives 8-bit asynchronous low-speed timing.

The timing is built from two cascaded counters. A divisor counter wraps every n+1 clocks, where n is the active divisor. A phase counter advances once per wrap and wraps after M steps, where M is the multiplier. The clock count of one bit is therefore P = M*(n+1).

Top module: `baud_gen`

## Requirements
- R1: After reset the divisor is 0 and all mode bits are 0. `baud_tick` and `sample_tick` are low during reset. The first `baud_tick` is high in the 64th cycle after reset is released.
- R2: When `cfg_wide`=0, only the low divisor byte forms n. The high byte is held but has no effect on the tick timing.
- R3: When `cfg_wide`=1, n is {high byte, low byte}, with the high byte in bits 15..8.
- R4: If `cfg_sync`=0, `cfg_wide`=0 and `cfg_fast`=0, then M=64.
- R5: If `cfg_sync`=0 and exactly one of `cfg_wide` and `cfg_fast` is 1, then M=16.
- R6: If `cfg_sync`=0 and both `cfg_wide` and `cfg_fast` are 1, then M=4. If `cfg_sync`=1, then M=4 whatever `cfg_fast` is. With n=0 and M=4, ticks come every 4 clocks.
- R7: A write to either divisor byte (`wr_lo` or `wr_hi`) clears both counters in the write cycle. Call the write cycle cycle 0. The next `baud_tick` is then high in cycle P, and P is computed from the new divisor.
- R8: `cfg_wr` loads `cfg_sync`, `cfg_wide` and `cfg_fast`. It clears both counters in the same way as R7.
- R9: `baud_tick` is high for exactly one cycle per bit, and consecutive ticks are P cycles apart.
- R10: Number the cycles of a bit c = 0 .. P-1 from the last clear or wrap. `sample_tick` is high when c mod (n+1) = n and c/(n+1) is M/2-1, M/2 or M/2+1. That gives three pulses per bit, and the last one falls on the `baud_tick` when M=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_lo | input | 1 | Write strobe for the low divisor byte |
| wr_hi | input | 1 | Write strobe for the high divisor byte |
| wr_data | input | 8 | Byte written by `wr_lo` or `wr_hi` |
| cfg_wr | input | 1 | Strobe that loads the three mode bits |
| cfg_sync | input | 1 | Synchronous operation select |
| cfg_wide | input | 1 | Selects the 16-bit divisor |
| cfg_fast | input | 1 | High-speed select, used only when asynchronous |
| baud_tick | output | 1 | One-cycle pulse at the end of each bit |
| sample_tick | output | 1 | Three pulses per bit around mid-bit |

## Verification
The hardest case to reach is a write that lands partway through a period. It must restart both the divisor counter and the phase counter, even when the phase counter is far from wrapping. The stimulus first lets a period run past several sub-interval boundaries. It then writes a byte, or reloads the mode, without changing the rate, so a missed clear would show up as an early tick. The reference model restarts its own cycle count on every write. It then checks each output on every clock across all eight mode combinations, with divisors that use the high byte. That includes the 4-clock period at n=0, where the three sample pulses fall on consecutive cycles.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int PH_W = 6;

    typedef enum logic [1:0] {
        OVS_X4  = 2'd0,
        OVS_X16 = 2'd1,
        OVS_X64 = 2'd2
    } ovs_e;

    function automatic logic [PH_W-1:0] phase_last(input ovs_e sel);
        unique case (sel)
            OVS_X4:  return PH_W'(3);
            OVS_X16: return PH_W'(15);
            default: return PH_W'(63);
        endcase
    endfunction
endpackage

// File: rtl/baud_mode_dec.sv
module baud_mode_dec
    import baud_pkg::*;
(
    input  logic sync_mode,
    input  logic wide_mode,
    input  logic fast_mode,
    output ovs_e sel
);
    always_comb begin
        if (sync_mode || (wide_mode && fast_mode))
            sel = OVS_X4;
        else if (wide_mode ^ fast_mode)
            sel = OVS_X16;
        else
            sel = OVS_X64;
    end
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || wrap)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/baud_phase_counter.sv
module baud_phase_counter
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  ovs_e sel,
    output logic last,
    output logic mid
);
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] term;
    logic [PH_W-1:0] half;

    assign term = phase_last(sel);
    assign half = (term >> 1) + 1'b1;
    assign last = (ph_q == term);
    assign mid  = (ph_q == half - 1'b1) || (ph_q == half) || (ph_q == half + 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ph_q <= '0;
        else if (clr)
            ph_q <= '0;
        else if (step)
            ph_q <= last ? '0 : ph_q + 1'b1;
    end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              cfg_wr,
    input  logic              cfg_sync,
    input  logic              cfg_wide,
    input  logic              cfg_fast,
    output logic              baud_tick,
    output logic              sample_tick
);
    localparam int DIV_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_q, hi_q;
    logic              sync_q, wide_q, fast_q;
    logic [DIV_W-1:0]  limit;
    logic              clr, div_wrap, ph_last, ph_mid;
    ovs_e              sel;

    assign clr = wr_lo | wr_hi | cfg_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            sync_q <= 1'b0;
            wide_q <= 1'b0;
            fast_q <= 1'b0;
        end else begin
            if (wr_lo) lo_q <= wr_data;
            if (wr_hi) hi_q <= wr_data;
            if (cfg_wr) begin
                sync_q <= cfg_sync;
                wide_q <= cfg_wide;
                fast_q <= cfg_fast;
            end
        end
    end

    assign limit = wide_q ? {hi_q, lo_q} : {{BYTE_W{1'b0}}, lo_q};

    baud_mode_dec u_dec (
        .sync_mode(sync_q),
        .wide_mode(wide_q),
        .fast_mode(fast_q),
        .sel      (sel)
    );

    baud_div_counter #(.W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .limit(limit),
        .wrap (div_wrap)
    );

    baud_phase_counter u_ph (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .step (div_wrap),
        .sel  (sel),
        .last (ph_last),
        .mid  (ph_mid)
    );

    always_comb begin
        baud_tick   = div_wrap & ph_last;
        sample_tick = div_wrap & ph_mid;
    end
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_lo,
    input logic wr_hi,
    input logic cfg_wr,
    input logic baud_tick,
    input logic sample_tick
);
    logic [7:0] gap_q;
    logic [1:0] samp_q;
    logic       any_wr;

    assign any_wr = wr_lo | wr_hi | cfg_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            samp_q <= '0;
        end else begin
            if (baud_tick || any_wr) gap_q <= '0;
            else if (gap_q != 8'hFF) gap_q <= gap_q + 1'b1;
            if (baud_tick || any_wr) samp_q <= '0;
            else if (sample_tick && samp_q != 2'd3) samp_q <= samp_q + 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!baud_tick && !sample_tick));

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> (!baud_tick && !sample_tick));

    p_cfg_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !baud_tick);

    p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);

    p_min_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> (gap_q >= 8'd3));

    p_three_samples_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> (samp_q < 2'd3));
endmodule

bind baud_gen baud_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_lo      (wr_lo),
    .wr_hi      (wr_hi),
    .cfg_wr     (cfg_wr),
    .baud_tick  (baud_tick),
    .sample_tick(sample_tick)
);

// File: tb/tb_baud_gen.sv
`timescale 1ns/1ps
module tb_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_lo = 1'b0, wr_hi = 1'b0, cfg_wr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cfg_sync = 1'b0, cfg_wide = 1'b0, cfg_fast = 1'b0;
    logic       baud_tick, sample_tick;

    int    n_vec = 0, n_bad = 0;
    string cur_req = "R1";

    int m_lo = 0, m_hi = 0, m_cnt = 0;
    bit m_sync = 0, m_wide = 0, m_fast = 0;

    always #5 clk = ~clk;

    baud_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .cfg_wr(cfg_wr), .cfg_sync(cfg_sync), .cfg_wide(cfg_wide), .cfg_fast(cfg_fast),
        .baud_tick(baud_tick), .sample_tick(sample_tick)
    );

    function automatic int mult();
        if (m_sync || (m_wide && m_fast)) return 4;
        if (m_wide != m_fast) return 16;
        return 64;
    endfunction

    function automatic int divn();
        return m_wide ? (m_hi * 256 + m_lo) : m_lo;
    endfunction

    task automatic check_out();
        int  n   = divn();
        int  m   = mult();
        int  p   = m * (n + 1);
        int  sub = m_cnt / (n + 1);
        bit  eb  = (m_cnt == p - 1);
        bit  es  = ((m_cnt % (n + 1)) == n) && (sub >= m/2 - 1) && (sub <= m/2 + 1);
        n_vec++;
        if (baud_tick !== eb || sample_tick !== es) begin
            n_bad++;
            $display("FAIL %s: baud/sample actual %b%b expected %b%b (count %0d of %0d)",
                     cur_req, baud_tick, sample_tick, eb, es, m_cnt, p);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        if (wr_lo || wr_hi || cfg_wr) begin
            if (wr_lo) m_lo = wr_data;
            if (wr_hi) m_hi = wr_data;
            if (cfg_wr) begin m_sync = cfg_sync; m_wide = cfg_wide; m_fast = cfg_fast; end
            m_cnt = 0;
        end else begin
            m_cnt = (m_cnt + 1) % (mult() * (divn() + 1));
        end
        @(negedge clk);
        check_out();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic put_lo(input int v);
        wr_lo = 1'b1; wr_data = 8'(v); cyc(); wr_lo = 1'b0;
    endtask

    task automatic put_hi(input int v);
        wr_hi = 1'b1; wr_data = 8'(v); cyc(); wr_hi = 1'b0;
    endtask

    task automatic put_cfg(input bit s, input bit w, input bit f);
        cfg_wr = 1'b1; cfg_sync = s; cfg_wide = w; cfg_fast = f; cyc(); cfg_wr = 1'b0;
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check_out();
        rst_n = 1'b1;
        run(130);

        // R4, R5, R6: every mode combination, divisor using both bytes
        put_hi(1);
        put_lo(2);
        for (int c = 0; c < 8; c++) begin
            bit s = c[2], w = c[1], f = c[0];
            if (s || (w && f)) cur_req = "R6";
            else if (w != f)   cur_req = "R5";
            else               cur_req = "R4";
            put_cfg(s, w, f);
            run(2 * mult() * (divn() + 1) + 5);
        end

        // R2: high byte ignored in 8-bit mode
        cur_req = "R2";
        put_cfg(0, 0, 1);
        put_hi(8'hF0);
        run(200);

        // R3: wide divisor {hi,lo}
        cur_req = "R3";
        put_cfg(0, 1, 1);
        put_hi(2);
        put_lo(0);
        run(4 * 513 * 2 + 3);

        // R6 / R10: n=0 in x4 mode, sync with fast set
        cur_req = "R6";
        put_cfg(1, 0, 1);
        put_lo(0);
        run(20);
        cur_req = "R10";
        put_cfg(1, 0, 0);
        run(20);

        // R7: mid-period byte writes restart the count
        cur_req = "R7";
        put_cfg(0, 0, 0);
        put_lo(3);
        run(150);
        put_lo(3);
        run(100);
        put_hi(5);
        run(300);

        // R8: mode reload mid-period restarts
        cur_req = "R8";
        run(77);
        put_cfg(0, 0, 0);
        run(300);

        // R9 / R10: plain run at x16
        cur_req = "R9";
        put_cfg(0, 0, 1);
        put_lo(1);
        run(200);

        finish_up();
    end
endmodule